// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is a bank of output cells for a sum-of-products logic device. Each cell receives the OR result of its own product-term group and its own output-enable term. A synchronous preset term and an asynchronous clear term are shared by every cell. Each cell has two configuration bits. One chooses whether the pin carries the OR result directly or the content of a D flip-flop that samples the OR result on each rising clock edge. The other chooses active-high or active-low polarity. Together they give four modes.

The pad is modelled by three signals: a data output, an enable output and a pad input. Each cell also returns a feedback bit to the logic array. In registered mode the feedback is the flip-flop state. In combinational mode the feedback is the pin level, so a cell whose enable is off works as a plain input. A synchronous active-high reset clears every flip-flop at power-up.

Top module: `mc_bank`

## Requirements
- R1: After a clock edge with `rst`=1, every flip-flop holds 0. A registered cell then drives `pin_out`=0 when `cfg_act_high`=1 and `pin_out`=1 when `cfg_act_high`=0.
- R2: When `cfg_reg_en[i]`=0 (combinational), `pin_out[i]` equals `sum_in[i]` if `cfg_act_high[i]`=1 and its inverse if it is 0, with no clock edge needed.
- R3: When `cfg_reg_en[i]`=1 (registered), the flip-flop takes `sum_in[i]` at each rising edge where neither preset nor clear is true. `pin_out[i]` then shows that state, inverted when `cfg_act_high[i]`=0.
- R4: A rising edge with `preset_term`=1 and `clear_term`=0 sets every flip-flop to 1.
- R5: While `clear_term`=1, every flip-flop is 0 straight away, without waiting for a clock edge.
- R6: When `preset_term` and `clear_term` are both 1, the flip-flops are 0. Clear takes priority.
- R7: `pin_oe[i]` follows `oe_term[i]` combinationally. The value on `pin_out[i]` does not depend on the enable.
- R8: In registered mode, `fb_out[i]` is the true flip-flop state, whatever the polarity setting.
- R9: In combinational mode, `fb_out[i]` equals `pin_out[i]` while `oe_term[i]`=1 and equals `pin_in[i]` while `oe_term[i]`=0.
- R10: Each cell follows its own two configuration bits. Cells with different modes in the same cycle do not affect one another.
- R11: The flip-flop keeps sampling in combinational mode. A cell switched to registered mode shows the value taken at the most recent edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high power-up reset |
| sum_in | input | NCELL | OR result of each cell's term group |
| oe_term | input | NCELL | Output-enable product term per cell |
| preset_term | input | 1 | Shared synchronous preset term |
| clear_term | input | 1 | Shared asynchronous clear term |
| cfg_reg_en | input | NCELL | 1 = registered, 0 = combinational |
| cfg_act_high | input | NCELL | 1 = active-high, 0 = active-low |
| pin_in | input | NCELL | Level seen at each pad |
| pin_out | output | NCELL | Data driven toward each pad |
| pin_oe | output | NCELL | Pad driver enable; 0 means high impedance |
| fb_out | output | NCELL | Feedback to the logic array |

## Verification
There are two kinds of result. Combinational results (pin data in combinational mode, enable, pad feedback, and the effect of clear) are due in the same cycle as the stimulus. Registered results (capture, preset, reset) appear one rising edge later. The bench changes its inputs at the falling edge and compares every output one nanosecond later, before the next rising edge. Its model updates its flip-flop image only at rising edges and forces that image to zero at once whenever clear is high. This way both kinds of result are checked in the cycle they are due.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef struct packed {
    logic reg_en;    // 1 = registered path
    logic act_high;  // 1 = true polarity
  } cell_cfg_t;

  localparam int unsigned CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/mc_dff.sv
module mc_dff (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic pre,
  input  logic d,
  output logic q
);
  // Asynchronous clear has top priority, then power-up reset, then preset.
  always_ff @(posedge clk or posedge clr) begin
    if (clr)      q <= 1'b0;
    else if (rst) q <= 1'b0;
    else if (pre) q <= 1'b1;
    else          q <= d;
  end
endmodule

// File: rtl/mc_outsel.sv
module mc_outsel
  import mc_pkg::*;
(
  input  cell_cfg_t cfg,
  input  logic      sum,
  input  logic      q,
  input  logic      oe,
  input  logic      pad,
  output logic      dout,
  output logic      fb
);
  logic path_sel;

  // Type select: registered state or direct sum.
  assign path_sel = cfg.reg_en ? q : sum;
  // Polarity select.
  assign dout     = cfg.act_high ? path_sel : ~path_sel;
  // Feedback: register state, or the level present on the pad.
  assign fb       = cfg.reg_en ? q : (oe ? dout : pad);
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      pre,
  input  cell_cfg_t cfg,
  input  logic      sum,
  input  logic      oe,
  input  logic      pad,
  output logic      dout,
  output logic      den,
  output logic      fb
);
  logic q;

  mc_dff u_ff (
    .clk (clk),
    .rst (rst),
    .clr (clr),
    .pre (pre),
    .d   (sum),
    .q   (q)
  );

  mc_outsel u_sel (
    .cfg  (cfg),
    .sum  (sum),
    .q    (q),
    .oe   (oe),
    .pad  (pad),
    .dout (dout),
    .fb   (fb)
  );

  assign den = oe;
endmodule

// File: rtl/mc_bank.sv
module mc_bank
  import mc_pkg::*;
#(
  parameter int unsigned NCELL = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCELL-1:0] sum_in,
  input  logic [NCELL-1:0] oe_term,
  input  logic             preset_term,
  input  logic             clear_term,
  input  logic [NCELL-1:0] cfg_reg_en,
  input  logic [NCELL-1:0] cfg_act_high,
  input  logic [NCELL-1:0] pin_in,
  output logic [NCELL-1:0] pin_out,
  output logic [NCELL-1:0] pin_oe,
  output logic [NCELL-1:0] fb_out
);
  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    cell_cfg_t cfg_i;
    assign cfg_i.reg_en   = cfg_reg_en[i];
    assign cfg_i.act_high = cfg_act_high[i];

    mc_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .clr  (clear_term),
      .pre  (preset_term),
      .cfg  (cfg_i),
      .sum  (sum_in[i]),
      .oe   (oe_term[i]),
      .pad  (pin_in[i]),
      .dout (pin_out[i]),
      .den  (pin_oe[i]),
      .fb   (fb_out[i])
    );
  end
endmodule

// File: rtl/mc_bank_chk.sv
module mc_bank_chk #(
  parameter int unsigned NCELL = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [NCELL-1:0] sum_in,
  input logic [NCELL-1:0] oe_term,
  input logic             preset_term,
  input logic             clear_term,
  input logic [NCELL-1:0] cfg_reg_en,
  input logic [NCELL-1:0] cfg_act_high,
  input logic [NCELL-1:0] pin_in,
  input logic [NCELL-1:0] pin_out,
  input logic [NCELL-1:0] pin_oe,
  input logic [NCELL-1:0] fb_out
);
  for (genvar i = 0; i < NCELL; i++) begin : g_chk
    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (clear_term && cfg_reg_en[i]) |-> !fb_out[i]);

    // R4
    preset_set_chk: assert property (@(posedge clk) disable iff (rst)
      (preset_term && !clear_term && cfg_reg_en[i])
        |=> (clear_term || !cfg_reg_en[i] || fb_out[i]));

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (rst)
      (!preset_term && !clear_term && cfg_reg_en[i])
        |=> (clear_term || !cfg_reg_en[i] || (fb_out[i] == $past(sum_in[i]))));

    // R9
    pad_feedback_chk: assert property (@(posedge clk) disable iff (rst)
      (!cfg_reg_en[i] && !oe_term[i]) |-> (fb_out[i] == pin_in[i]));

    // R8
    reg_polarity_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_reg_en[i] |-> (pin_out[i] == (cfg_act_high[i] ? fb_out[i] : !fb_out[i])));
  end
endmodule

bind mc_bank mc_bank_chk #(.NCELL(NCELL)) u_chk (.*);

// File: tb/tb_mc_bank.sv
`timescale 1ns/1ps
module tb_mc_bank;
  localparam int N = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] sum_in = '0, oe_term = '0, cfg_reg_en = '0, cfg_act_high = '0, pin_in = '0;
  logic         preset_term = 1'b0, clear_term = 1'b0;
  logic [N-1:0] pin_out, pin_oe, fb_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit q_m [N];
  string phase = "R1";

  always #2 clk = ~clk;  // 250 MHz

  mc_bank #(.NCELL(N)) dut (.*);

  // Model: flip-flop image updated at rising edges.
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (clear_term || rst) q_m[i] = 1'b0;
      else if (preset_term)  q_m[i] = 1'b1;
      else                   q_m[i] = sum_in[i];
    end
  end

  task automatic chk(string tag, int idx, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s[%0d] act=%b exp=%b", tag, what, idx, act, exp);
    end
  endtask

  // Compare all outputs; called 1 ns after inputs change at the falling edge.
  task automatic compare_all();
    #1;
    for (int i = 0; i < N; i++) begin
      bit qv, sel, dexp, fexp;
      qv   = clear_term ? 1'b0 : q_m[i];   // async clear (R5)
      sel  = cfg_reg_en[i] ? qv : sum_in[i];
      dexp = cfg_act_high[i] ? sel : !sel;
      fexp = cfg_reg_en[i] ? qv : (oe_term[i] ? dexp : pin_in[i]);
      chk({phase, cfg_reg_en[i] ? "/R3" : "/R2"}, i, "pin_out", pin_out[i], dexp);
      chk({phase, "/R7"}, i, "pin_oe", pin_oe[i], oe_term[i]);
      chk({phase, cfg_reg_en[i] ? "/R8" : "/R9"}, i, "fb_out", fb_out[i], fexp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic rand_inputs(bit rnd_cfg);
    sum_in  = N'($urandom);
    oe_term = N'($urandom);
    pin_in  = N'($urandom);
    if (rnd_cfg) begin
      cfg_reg_en   = N'($urandom);
      cfg_act_high = N'($urandom);
    end
  endtask

  initial begin
    // R1: reset with registered cells of both polarities
    cfg_reg_en   = '1;
    cfg_act_high = N'(10'b1010101010);
    oe_term      = '1;
    sum_in       = '1;
    repeat (2) @(posedge clk);
    cyc();
    phase = "R1";
    compare_all();
    rst = 1'b0;

    // R2: combinational, both polarities
    phase = "R2";
    cfg_reg_en = '0;
    for (int k = 0; k < 20; k++) begin
      cyc(); rand_inputs(1'b0); cfg_act_high = N'($urandom); compare_all();
    end

    // R3: registered capture
    phase = "R3";
    cfg_reg_en = '1;
    for (int k = 0; k < 20; k++) begin
      cyc(); rand_inputs(1'b0); compare_all();
    end

    // R4: synchronous preset
    phase = "R4";
    cyc(); sum_in = '0; preset_term = 1'b1; compare_all();
    cyc(); preset_term = 1'b0; compare_all();

    // R5: clear mid-cycle, no edge needed
    phase = "R5";
    cyc(); clear_term = 1'b1; compare_all();
    cyc(); clear_term = 1'b0; sum_in = '1; compare_all();

    // R6: preset and clear together
    phase = "R6";
    cyc(); compare_all();
    cyc(); preset_term = 1'b1; clear_term = 1'b1; compare_all();
    cyc(); compare_all();
    cyc(); preset_term = 1'b0; clear_term = 1'b0; compare_all();

    // R11: sample in combinational mode, then switch to registered
    phase = "R11";
    cyc(); cfg_reg_en = '0; sum_in = N'(10'b1100110011); compare_all();
    cyc(); sum_in = '0; cfg_reg_en = '1; compare_all();

    // R7 / R9: enable toggling with pad input in combinational mode
    phase = "R9";
    cfg_reg_en = '0;
    for (int k = 0; k < 20; k++) begin
      cyc(); rand_inputs(1'b0); compare_all();
    end

    // R10: mixed per-cell configuration, occasional preset/clear
    phase = "R10";
    for (int k = 0; k < 200; k++) begin
      cyc();
      rand_inputs(1'b1);
      preset_term = ($urandom % 8) == 0;
      clear_term  = ($urandom % 11) == 0;
      compare_all();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule